// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block is the interrupt bookkeeping register of a seven-channel DMA engine, together with the gate that decides whether a write to a channel's control word actually launches that channel. The 32-bit interrupt word has four kinds of content. There are per-channel interrupt enables and a master enable. There is a force bit that also stands for a bus error. There are per-channel completion flags, and there is a read-only "sent" bit. The transfer engine drives a one-cycle done pulse per channel. When that channel's enable is set, the pulse raises the matching flag. Software acknowledges a flag by writing a one to it.

Whenever the interrupt condition is true, the sent bit is set. The condition is true when the master enable is set and at least one flag is raised, or when the force bit is set. The block sends a single-cycle request to the system interrupt controller only when the sent bit goes from clear to set. The request is therefore an edge and not a level. Once the condition has been reported, further flags raise no new request until the condition has been seen false.

The block also holds a channel enable word and one control word per channel. A control-word write with the start bit set produces a one-cycle start pulse for that channel. This happens only if the channel's enable bit in the channel enable word is set.

Top module: `dma_irq_ctl`

## Requirements
- R1: After reset the interrupt word (offset 0x0F4), the channel enable word (offset 0x0F0) and every channel control word read as zero, and irq_o and chan_start_o are low.
- R2: A write to 0x0F4 stores only the bits of mask 0x00FF803F: low bits 5..0, force bit 15, channel enables 22..16 and master enable 23. Written values of bits 14..6 and of bit 31 are not stored.
- R3: A done pulse on channel n sets flag bit 24+n only when enable bit 16+n is set. The enable value used is the one after any write in the same cycle.
- R4: Writing 1 to a flag bit (30..24) clears it, and writing 0 to it leaves it unchanged.
- R5: Bit 31 (sent) reads 1 exactly when (bit 23 and any flag set) or bit 15 is set. It clears as soon as that condition is false.
- R6: irq_o is a one-cycle pulse, raised on the clock edge at which sent goes from 0 to 1. No further pulse follows while sent stays 1.
- R7: The force bit 15 alone raises the condition, and so the request, with the master enable clear and no flags set.
- R8: A write of a word with bit 24 set to the control word of channel n (offset 0x088 + 0x10*n) gives a one-cycle pulse on chan_start_o[n] one cycle after the write. This happens only if bit 3+4*n of the channel enable word is set. Otherwise no pulse occurs.
- R9: When a done pulse and a write that clears the same flag fall in the same cycle, the flag ends up set.
- R10: The channel enable word at 0x0F0 and each channel control word read back the full 32-bit value last written. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| waddr_i | input | ADDR_W | Byte offset of the write |
| wdata_i | input | 32 | Write data |
| raddr_i | input | ADDR_W | Byte offset of the combinational read |
| rdata_o | output | 32 | Read data |
| done_i | input | NUM_CH | One-cycle completion pulses, one per channel |
| irq_o | output | 1 | One-cycle request to the interrupt controller |
| chan_start_o | output | NUM_CH | One-cycle channel start pulses |

## Verification
A completion pulse and a software acknowledge of the same flag can arrive in the same cycle. The bench provokes this by driving done_i for a channel in the very cycle that writes a one to that channel's flag. It expects the flag to survive, the sent bit to rise and exactly one request pulse to reach the scoreboard. Pulses for the other cases are also predicted in a queue ahead of time. Any unexpected or missing request or start pulse counts as a failure.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   // Bit positions inside the interrupt word
   localparam int LOW_W      = 6;
   localparam int FORCE_BIT  = 15;
   localparam int ENA_LSB    = 16;
   localparam int MASTER_BIT = 23;
   localparam int FLAG_LSB   = 24;
   localparam int SENT_BIT   = 31;
   localparam int MAX_CH     = 7;

   // Register offsets
   localparam int CH_BASE    = 'h080;
   localparam int CH_STRIDE  = 'h010;
   localparam int CTL_OFS    = 'h008;
   localparam int CHEN_OFS   = 'h0F0;
   localparam int ICR_OFS    = 'h0F4;

   // Control-word start bit and channel-enable nibble stride
   localparam int START_BIT  = 24;
   localparam int CHEN_BIT   = 3;
   localparam int CHEN_STEP  = 4;

   function automatic int ctl_offset(input int ch);
      return CH_BASE + CH_STRIDE * ch + CTL_OFS;
   endfunction
endpackage

// File: rtl/dma_irq_icr.sv
module dma_irq_icr
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 7
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [31:0]       wdata,
   input  logic [NUM_CH-1:0] done,
   output logic [31:0]       icr_q,
   output logic              irq_o
);
   localparam logic [31:0] CH_ONES   = 32'((1 << NUM_CH) - 1);
   localparam logic [31:0] ENA_MASK  = CH_ONES << ENA_LSB;
   localparam logic [31:0] FLAG_MASK = CH_ONES << FLAG_LSB;
   localparam logic [31:0] LOW_MASK  = 32'((1 << LOW_W) - 1);
   localparam logic [31:0] WR_MASK   = ENA_MASK | LOW_MASK |
                                       (32'd1 << FORCE_BIT) | (32'd1 << MASTER_BIT);
   localparam logic [31:0] SENT_MASK = 32'd1 << SENT_BIT;

   logic [31:0]       base;
   logic [31:0]       nxt;
   logic [NUM_CH-1:0] ena;
   logic [NUM_CH-1:0] flg;
   logic              cond;

   always_comb begin
      if (wr_en)
         base = (wdata & WR_MASK) | (icr_q & FLAG_MASK & ~wdata);
      else
         base = icr_q & ~SENT_MASK;
      ena  = base[ENA_LSB +: NUM_CH];
      flg  = base[FLAG_LSB +: NUM_CH] | (done & ena);
      cond = (base[MASTER_BIT] && (|flg)) || base[FORCE_BIT];
      nxt  = base;
      nxt[FLAG_LSB +: NUM_CH] = flg;
      nxt[SENT_BIT]           = cond;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         icr_q <= '0;
         irq_o <= 1'b0;
      end else begin
         icr_q <= nxt;
         irq_o <= cond && !icr_q[SENT_BIT];
      end
   end
endmodule

// File: rtl/dma_chan_gate.sv
module dma_chan_gate
   import dma_irq_pkg::*;
#(
   parameter bit START_REG = 1'b1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sel,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   input  logic        chan_en,
   output logic [31:0] ctl_q,
   output logic        start_o
);
   logic go;
   assign go = wr_en && sel && wdata[START_BIT] && chan_en;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (wr_en && sel)
         ctl_q <= wdata;
   end

   generate
      if (START_REG) begin : g_reg_start
         logic start_q;
         always_ff @(posedge clk) begin
            if (!rst_n) start_q <= 1'b0;
            else        start_q <= go;
         end
         assign start_o = start_q;
      end else begin : g_comb_start
         assign start_o = go;
      end
   endgenerate
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH    = 7,
   parameter int ADDR_W    = 12,
   parameter bit START_REG = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [31:0]       wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [31:0]       rdata_o,
   input  logic [NUM_CH-1:0] done_i,
   output logic              irq_o,
   output logic [NUM_CH-1:0] chan_start_o
);
   localparam int TOP_OFS = ICR_OFS;

   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("NUM_CH must lie in 1..7");
      end
      if (ADDR_W < 8 || ADDR_W > 31 || (1 << ADDR_W) <= TOP_OFS) begin : g_bad_aw
         $error("ADDR_W must cover the register offsets");
      end
   endgenerate

   logic [31:0]       icr_q;
   logic [31:0]       en_q;
   logic              wr_icr;
   logic              wr_chen;
   logic [31:0]       ctl_q [NUM_CH];

   assign wr_icr  = wr_en_i && (32'(waddr_i) == ICR_OFS);
   assign wr_chen = wr_en_i && (32'(waddr_i) == CHEN_OFS);

   always_ff @(posedge clk) begin
      if (!rst_n)       en_q <= '0;
      else if (wr_chen) en_q <= wdata_i;
   end

   dma_irq_icr #(.NUM_CH(NUM_CH)) icr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_icr),
      .wdata (wdata_i),
      .done  (done_i),
      .icr_q (icr_q),
      .irq_o (irq_o)
   );

   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
         localparam int MY_OFS = ctl_offset(n);
         logic sel;
         assign sel = (32'(waddr_i) == MY_OFS);
         dma_chan_gate #(.START_REG(START_REG)) gate_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (sel),
            .wr_en   (wr_en_i),
            .wdata   (wdata_i),
            .chan_en (en_q[CHEN_BIT + CHEN_STEP * n]),
            .ctl_q   (ctl_q[n]),
            .start_o (chan_start_o[n])
         );
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      if (32'(raddr_i) == ICR_OFS)  rdata_o = icr_q;
      if (32'(raddr_i) == CHEN_OFS) rdata_o = en_q;
      for (int n = 0; n < NUM_CH; n++) begin
         if (32'(raddr_i) == ctl_offset(n)) rdata_o = ctl_q[n];
      end
   end
endmodule

// File: rtl/dma_irq_ctl_chk.sv
module dma_irq_ctl_chk
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 7
)(
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       icr,
   input logic [31:0]       en_reg,
   input logic              irq,
   input logic [NUM_CH-1:0] start,
   input logic              wr_en
);
   localparam logic [31:0] CH_ONES = 32'((1 << NUM_CH) - 1);
   localparam logic [31:0] KEEP    = (CH_ONES << ENA_LSB) | (CH_ONES << FLAG_LSB) |
                                     32'h0000_003F | (32'd1 << FORCE_BIT) |
                                     (32'd1 << MASTER_BIT) | (32'd1 << SENT_BIT);

   logic [NUM_CH-1:0] gate_bits;
   always_comb begin
      for (int n = 0; n < NUM_CH; n++) gate_bits[n] = en_reg[CHEN_BIT + CHEN_STEP * n];
   end

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (icr == '0 && !irq && start == '0));

   p_unstored_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (icr & ~KEEP) == '0);

   p_flag_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (icr[FLAG_LSB +: NUM_CH] & ~$past(icr[FLAG_LSB +: NUM_CH]) &
       ~icr[ENA_LSB +: NUM_CH]) == '0);

   p_sent_tracks_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
      icr[SENT_BIT] == ((icr[MASTER_BIT] && (|icr[FLAG_LSB +: NUM_CH])) || icr[FORCE_BIT]));

   p_irq_with_sent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> icr[SENT_BIT]);

   p_irq_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_start_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|start) |-> $past(wr_en));

   p_start_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start & ~gate_bits) == '0);
endmodule

bind dma_irq_ctl dma_irq_ctl_chk #(.NUM_CH(NUM_CH)) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .icr    (icr_q),
   .en_reg (en_q),
   .irq    (irq_o),
   .start  (chan_start_o),
   .wr_en  (wr_en_i)
);

// File: tb/dma_irq_ctl_tb_top.sv
`timescale 1ns/1ps
module dma_irq_ctl_tb_top;
   localparam int NCH = 7;
   localparam int AW  = 12;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [AW-1:0]  waddr = '0;
   logic [31:0]    wdata = '0;
   logic [AW-1:0]  raddr = '0;
   logic [31:0]    rdata;
   logic [NCH-1:0] done = '0;
   logic           irq;
   logic [NCH-1:0] start;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  ended  = 1'b0;

   typedef struct {
      int             kind;   // 0 request pulse, 1 start pulse
      logic [NCH-1:0] val;
      string          req;
   } ev_t;
   ev_t evq[$];

   always #2.5 clk = ~clk;

   dma_irq_ctl #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .waddr_i(waddr), .wdata_i(wdata),
      .raddr_i(raddr), .rdata_o(rdata), .done_i(done), .irq_o(irq), .chan_start_o(start)
   );

   // Monitor: every observed pulse must match the head of the expectation queue
   always @(negedge clk) begin
      if (rst_n && !ended) begin
         if (irq) begin
            n_chk++;
            if (evq.size() == 0 || evq[0].kind != 0) begin
               n_fail++;
               $display("FAIL R6 unexpected request pulse: got 1 expected 0");
            end else void'(evq.pop_front());
         end
         if (|start) begin
            n_chk++;
            if (evq.size() == 0 || evq[0].kind != 1 || evq[0].val != start) begin
               n_fail++;
               $display("FAIL R8 start pulse: got %b expected %b", start,
                        (evq.size() != 0 && evq[0].kind == 1) ? evq[0].val : '0);
            end else void'(evq.pop_front());
         end
      end
   end

   task automatic expect_irq(input string req);
      ev_t e; e.kind = 0; e.val = '0; e.req = req; evq.push_back(e);
   endtask

   task automatic expect_start(input logic [NCH-1:0] v, input string req);
      ev_t e; e.kind = 1; e.val = v; e.req = req; evq.push_back(e);
   endtask

   task automatic drive(input bit we, input int a, input logic [31:0] d, input logic [NCH-1:0] dn);
      @(negedge clk);
      wr_en = we; waddr = AW'(a); wdata = d; done = dn;
      @(negedge clk);
      wr_en = 1'b0; done = '0;
   endtask

   task automatic chk_rd(input int a, input logic [31:0] exp, input string req);
      raddr = AW'(a);
      #1;
      n_chk++;
      if (rdata !== exp) begin
         n_fail++;
         $display("FAIL %s read 0x%03h: got 0x%08h expected 0x%08h", req, a, rdata, exp);
      end
   endtask

   task automatic chk_queue_empty(input string req);
      n_chk++;
      if (evq.size() != 0) begin
         n_fail++;
         $display("FAIL %s missing pulses: got %0d pending expected 0", req, evq.size());
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_rd('h0F4, 32'h0, "R1");
      chk_rd('h0F0, 32'h0, "R1");
      chk_rd('h0A8, 32'h0, "R1");

      // R2 unstored bits
      drive(1, 'h0F4, 32'h7F00_7FC0, '0);
      chk_rd('h0F4, 32'h0, "R2");
      drive(1, 'h0F4, 32'h807F_003F, '0);
      chk_rd('h0F4, 32'h007F_003F, "R2");

      // R3 done pulses gated by enables
      drive(1, 'h0F4, 32'h0005_0000, '0);
      drive(0, 'h0, 32'h0, 7'h7F);
      chk_rd('h0F4, 32'h0505_0000, "R3");

      // R4 write-one clears, zero keeps
      drive(1, 'h0F4, 32'h0105_0000, '0);
      chk_rd('h0F4, 32'h0405_0000, "R4");

      // R5/R6 master enable raises condition
      expect_irq("R6");
      drive(1, 'h0F4, 32'h0085_0000, '0);
      chk_rd('h0F4, 32'h8485_0000, "R5");
      drive(0, 'h0, 32'h0, 7'h01);            // no repeat pulse
      chk_rd('h0F4, 32'h8585_0000, "R6");
      drive(1, 'h0F4, 32'h0585_0000, '0);     // clear both flags
      chk_rd('h0F4, 32'h0085_0000, "R5");
      expect_irq("R6");
      drive(0, 'h0, 32'h0, 7'h04);
      chk_rd('h0F4, 32'h8485_0000, "R6");
      drive(1, 'h0F4, 32'h0400_0000, '0);
      chk_rd('h0F4, 32'h0, "R5");

      // R7 force bit alone
      expect_irq("R7");
      drive(1, 'h0F4, 32'h0000_8000, '0);
      chk_rd('h0F4, 32'h8000_8000, "R7");
      drive(1, 'h0F4, 32'h0, '0);
      chk_rd('h0F4, 32'h0, "R7");

      // R9 done and clearing write in the same cycle
      drive(1, 'h0F4, 32'h0082_0000, '0);
      chk_rd('h0F4, 32'h0082_0000, "R9");
      expect_irq("R9");
      drive(1, 'h0F4, 32'h0282_0000, 7'h02);
      chk_rd('h0F4, 32'h8282_0000, "R9");
      drive(1, 'h0F4, 32'h0282_0000, '0);
      chk_rd('h0F4, 32'h0082_0000, "R9");

      // R10/R8 channel enable word and start gating
      drive(1, 'h0F0, 32'h0800_0080, '0);
      chk_rd('h0F0, 32'h0800_0080, "R10");
      expect_start(7'h02, "R8");
      drive(1, 'h098, 32'h0100_0002, '0);
      chk_rd('h098, 32'h0100_0002, "R10");
      drive(1, 'h088, 32'h0100_0000, '0);    // channel 0 not enabled
      chk_rd('h088, 32'h0100_0000, "R10");
      drive(1, 'h0E8, 32'h0000_0001, '0);    // start bit clear
      chk_rd('h0E8, 32'h0000_0001, "R10");
      expect_start(7'h40, "R8");
      drive(1, 'h0E8, 32'h0100_0000, '0);
      chk_rd('h0E4, 32'h0, "R10");
      repeat (3) @(negedge clk);
      chk_queue_empty("R8");

      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule